// File: doc/BRIEF.md
# Multi-Mode Display Host Write Engine

This block sits on the host side of a small graphic display driver. It sends command bytes and display-data bytes to the driver over one of three buses. A two-bit mode input picks the bus: an 8-bit parallel bus with a read/write select line and an enable strobe, an 8-bit parallel bus with separate active-low read and write strobes, or a 4-wire serial bus. Bytes arrive through a valid/ready handshake, and each byte comes with a flag that says whether it is a command or display data.

For every byte the engine runs one framed bus cycle. It drops chip select, drives the command/data line, and then either pulses the strobe of the selected parallel bus or shifts the byte out serially. It then raises chip select again and waits for a recovery gap before it accepts the next byte. Every phase length is a parameter counted in system-clock cycles, so the same sequencer meets the bus timing at any clock rate. All bus pins come from flops, so all of them move one clock after the sequencer state that drives them.

Top module: `disp_wr_engine`

## Requirements
- R1: The mode code is (bit1,bit0): 00 is 4-wire serial, 10 is the parallel bus with separate strobes (the "strobe-pair" bus), 11 is the parallel bus with an enable strobe (the "enable" bus). The code 01 (3-wire serial) is not supported. While mode_i is 01, mode_err_o is high one clock later, in_ready_o is low and no byte is accepted, so chip select stays high. mode_err_o is low for every other code.
- R2: A byte is accepted on a clock edge where in_valid_i and in_ready_o are both high. in_ready_o is high only when no transfer is in progress, so it is low from the edge after acceptance until the transfer has completed.
- R3: dc_o is low for a command byte (in_is_data_i=0) and high for a data byte (in_is_data_i=1). It takes its value when chip select falls and does not change while chip select is low.
- R4: Enable bus (mode 11): rw_wr_o (read/write select) stays low, and en_rd_o (enable) idles low and rises in one pulse while cs_no is low. The driver latches bus_o[7:0] on the falling edge of en_rd_o, and at that edge bus_o holds the byte.
- R5: Strobe-pair bus (mode 10): en_rd_o (read strobe) stays high, and rw_wr_o (write strobe) idles high and falls in one pulse while cs_no is low. The driver latches bus_o[7:0] on the rising edge of rw_wr_o, and at that edge bus_o holds the byte.
- R6: Parallel timing in clock cycles: the strobe starts at least PAR_SETUP cycles after chip select falls. The strobe stays active for at least PAR_ACT cycles. bus_o holds the byte for at least PAR_DSU cycles before the latching edge and for at least PAR_HOLD cycles after it, and it holds the byte for the whole time chip select is low.
- R7: Serial mode (mode 00): bus_o[0] is the serial clock, which idles low. bus_o[1] is the serial data, sent most-significant bit first and sampled by the driver on the rising clock edge. bus_o[7:2], en_rd_o and rw_wr_o stay low. Each frame has exactly 8 rising edges.
- R8: Serial timing in clock cycles: the first rising clock edge comes no earlier than SPI_CSS+SCK_LO cycles after chip select falls. Every later low phase lasts at least SCK_LO cycles and every high phase at least SCK_HI cycles. Chip select rises at least SPI_CSH cycles after the last falling clock edge, and data does not change while the clock is high.
- R9: Each byte gets its own chip-select-low frame with exactly one latching edge. Bytes leave the engine in the order they were accepted. After a frame, in_ready_o rises only once chip select has been high for at least one bus cycle: PAR_CYC cycles after a parallel byte, SCK_LO+SCK_HI cycles after a serial byte.
- R10: While rst_ni is low, cs_no is high, and en_rd_o, rw_wr_o, dc_o and bus_o are all zero. After reset, while idle, the strobes settle to the idle levels of the selected mode.
- R11: The mode is captured when a byte is accepted. A change of mode_i during a transfer does not affect that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Bus select code |
| in_valid_i | input | 1 | Byte offered |
| in_data_i | input | 8 | Byte to send |
| in_is_data_i | input | 1 | 1 = display data, 0 = command |
| in_ready_o | output | 1 | Engine can accept a byte |
| mode_err_o | output | 1 | Unsupported mode code selected |
| cs_no | output | 1 | Chip select, active low |
| dc_o | output | 1 | Data/command line |
| en_rd_o | output | 1 | Enable (enable bus) or read strobe (strobe-pair bus) |
| rw_wr_o | output | 1 | Read/write select (enable bus) or write strobe (strobe-pair bus) |
| bus_o | output | 8 | Parallel data; bit 0 serial clock and bit 1 serial data in serial mode |

## Verification
Two events can land on the same clock edge. The first pair is the end of the recovery gap and the handshake of the next byte: the driver offers each new byte as soon as in_ready_o rises, so back-to-back frames are separated only by the minimum gap. The monitor judges this case by counting the high cycles of chip select before ready and by matching frames to bytes one for one. The second pair is a mode change and a live transfer: the driver switches mode_i to a parallel code in the middle of a serial frame. The frame must still decode, bit by bit, as a correct serial byte against the mode stored with the queued item.

// File: rtl/disp_wr_pkg.sv
package disp_wr_pkg;
  typedef enum logic [1:0] {
    BUS_SPI4 = 2'b00,
    BUS_SPI3 = 2'b01,
    BUS_P80  = 2'b10,
    BUS_P68  = 2'b11
  } bus_mode_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ACT,
    PH_LO,
    PH_HI,
    PH_HOLD,
    PH_REC
  } phase_e;
endpackage

// File: rtl/disp_wr_timer.sv
module disp_wr_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] len_i,
  output logic          done_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= len_i - TW'(1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - TW'(1);
  end

  assign done_o = (cnt_q == '0);

  AST_LEN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (len_i != '0)); // R6
endmodule

// File: rtl/disp_wr_serial.sv
module disp_wr_serial (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  input  logic       step_i,
  output logic       bit_o,
  output logic       last_o
);
  logic [7:0] sh_q;
  logic [2:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      sh_q  <= byte_i;
      idx_q <= 3'd7;
    end else if (step_i) begin
      sh_q  <= {sh_q[6:0], 1'b0};
      idx_q <= idx_q - 3'd1;
    end
  end

  assign bit_o  = sh_q[7];   // msb first
  assign last_o = (idx_q == 3'd0);

  AST_NO_STEP_PAST_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> !last_o); // R7
endmodule

// File: rtl/disp_wr_pinmux.sv
module disp_wr_pinmux
  import disp_wr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  phase_e     ph_i,
  input  bus_mode_e  mode_q_i,
  input  bus_mode_e  mode_live_i,
  input  logic [7:0] byte_i,
  input  logic       dc_i,
  input  logic       ser_bit_i,
  output logic       cs_no,
  output logic       dc_o,
  output logic       en_rd_o,
  output logic       rw_wr_o,
  output logic [7:0] bus_o
);
  logic       busy, cs_d, e_d, w_d;
  logic [7:0] bus_d;
  bus_mode_e  m, pm_q;

  always_comb begin
    busy = (ph_i != PH_IDLE) && (ph_i != PH_REC);
    cs_d = !busy;
    m    = (ph_i == PH_IDLE) ? mode_live_i : mode_q_i;
    e_d  = 1'b0;
    w_d  = 1'b0;
    bus_d = '0;
    case (m)
      BUS_P68: begin
        e_d   = (ph_i == PH_ACT);
        bus_d = busy ? byte_i : 8'h00;
      end
      BUS_P80: begin
        e_d   = 1'b1;
        w_d   = (ph_i != PH_ACT);
        bus_d = busy ? byte_i : 8'h00;
      end
      default: begin
        bus_d[0] = (ph_i == PH_HI);
        bus_d[1] = ser_bit_i &&
                   ((ph_i == PH_SETUP) || (ph_i == PH_LO) || (ph_i == PH_HI));
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_no   <= 1'b1;
      dc_o    <= 1'b0;
      en_rd_o <= 1'b0;
      rw_wr_o <= 1'b0;
      bus_o   <= '0;
      pm_q    <= BUS_SPI4;
    end else begin
      cs_no   <= cs_d;
      dc_o    <= dc_i;
      en_rd_o <= e_d;
      rw_wr_o <= w_d;
      bus_o   <= bus_d;
      pm_q    <= m;
    end
  end

  AST_WR_INSIDE_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pm_q == BUS_P80 && !rw_wr_o) |-> !cs_no); // R5
  AST_EN_INSIDE_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pm_q == BUS_P68 && en_rd_o) |-> !cs_no); // R4
  AST_SPI_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pm_q[1] == 1'b0) |-> (bus_o[7:2] == '0 && !en_rd_o && !rw_wr_o)); // R7
endmodule

// File: rtl/disp_wr_engine.sv
module disp_wr_engine
  import disp_wr_pkg::*;
#(
  parameter int PAR_SETUP = 2,
  parameter int PAR_ACT   = 8,
  parameter int PAR_DSU   = 5,
  parameter int PAR_HOLD  = 1,
  parameter int PAR_CYC   = 38,
  parameter int SCK_LO    = 7,
  parameter int SCK_HI    = 6,
  parameter int SPI_CSS   = 3,
  parameter int SPI_CSH   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       in_valid_i,
  input  logic [7:0] in_data_i,
  input  logic       in_is_data_i,
  output logic       in_ready_o,
  output logic       mode_err_o,
  output logic       cs_no,
  output logic       dc_o,
  output logic       en_rd_o,
  output logic       rw_wr_o,
  output logic [7:0] bus_o
);
  localparam int ACT_LEN = (PAR_ACT > PAR_DSU - PAR_SETUP) ? PAR_ACT : (PAR_DSU - PAR_SETUP);
  localparam int SPI_CYC = SCK_LO + SCK_HI;
  localparam int MIN_REC = (PAR_CYC < SPI_CYC) ? PAR_CYC : SPI_CYC;
  localparam int SUM_LEN = PAR_SETUP + ACT_LEN + PAR_HOLD + PAR_CYC + SPI_CYC + SPI_CSS + SPI_CSH;
  localparam int TW      = $clog2(SUM_LEN + 1);

  localparam logic [TW-1:0] L_PSET = TW'(PAR_SETUP);
  localparam logic [TW-1:0] L_PACT = TW'(ACT_LEN);
  localparam logic [TW-1:0] L_PHLD = TW'(PAR_HOLD);
  localparam logic [TW-1:0] L_PCYC = TW'(PAR_CYC);
  localparam logic [TW-1:0] L_SLO  = TW'(SCK_LO);
  localparam logic [TW-1:0] L_SHI  = TW'(SCK_HI);
  localparam logic [TW-1:0] L_SCYC = TW'(SPI_CYC);
  localparam logic [TW-1:0] L_CSS  = TW'(SPI_CSS);
  localparam logic [TW-1:0] L_CSH  = TW'(SPI_CSH);

  phase_e        ph_q, ph_d;
  bus_mode_e     mode_q, mode_live;
  logic [7:0]    byte_q;
  logic          dc_q, accept, par_q;
  logic          tm_ld, tm_done, ser_ld, ser_step, ser_bit, ser_last;
  logic [TW-1:0] tm_len, cs_hi_cnt;

  assign mode_live  = bus_mode_e'(mode_i);
  assign in_ready_o = (ph_q == PH_IDLE) && (mode_live != BUS_SPI3);
  assign accept     = in_valid_i && in_ready_o;
  assign par_q      = mode_q[1];

  always_comb begin
    ph_d     = ph_q;
    tm_ld    = 1'b0;
    tm_len   = '0;
    ser_ld   = 1'b0;
    ser_step = 1'b0;
    case (ph_q)
      PH_IDLE: if (accept) begin
        ph_d = PH_SETUP; tm_ld = 1'b1; ser_ld = 1'b1;
        tm_len = mode_i[1] ? L_PSET : L_CSS;
      end
      PH_SETUP: if (tm_done) begin
        tm_ld = 1'b1;
        if (par_q) begin ph_d = PH_ACT; tm_len = L_PACT; end
        else       begin ph_d = PH_LO;  tm_len = L_SLO;  end
      end
      PH_ACT: if (tm_done) begin
        ph_d = PH_HOLD; tm_ld = 1'b1; tm_len = L_PHLD;
      end
      PH_LO: if (tm_done) begin
        ph_d = PH_HI; tm_ld = 1'b1; tm_len = L_SHI;
      end
      PH_HI: if (tm_done) begin
        tm_ld = 1'b1;
        if (ser_last) begin ph_d = PH_HOLD; tm_len = L_CSH; end
        else begin ph_d = PH_LO; tm_len = L_SLO; ser_step = 1'b1; end
      end
      PH_HOLD: if (tm_done) begin
        ph_d = PH_REC; tm_ld = 1'b1;
        tm_len = par_q ? L_PCYC : L_SCYC;
      end
      PH_REC: if (tm_done) ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q       <= PH_IDLE;
      mode_q     <= BUS_SPI4;
      byte_q     <= '0;
      dc_q       <= 1'b0;
      mode_err_o <= 1'b0;
    end else begin
      ph_q       <= ph_d;
      mode_err_o <= (mode_live == BUS_SPI3);
      if (accept) begin
        mode_q <= mode_live;
        byte_q <= in_data_i;
        dc_q   <= in_is_data_i;
      end
    end
  end

  disp_wr_timer #(.TW(TW)) u_timer (
    .clk_i (clk_i), .rst_ni (rst_ni), .load_i (tm_ld), .len_i (tm_len), .done_o (tm_done)
  );

  disp_wr_serial u_serial (
    .clk_i (clk_i), .rst_ni (rst_ni), .load_i (ser_ld), .byte_i (in_data_i),
    .step_i (ser_step), .bit_o (ser_bit), .last_o (ser_last)
  );

  disp_wr_pinmux u_pins (
    .clk_i (clk_i), .rst_ni (rst_ni), .ph_i (ph_q), .mode_q_i (mode_q),
    .mode_live_i (mode_live), .byte_i (byte_q), .dc_i (dc_q), .ser_bit_i (ser_bit),
    .cs_no (cs_no), .dc_o (dc_o), .en_rd_o (en_rd_o), .rw_wr_o (rw_wr_o), .bus_o (bus_o)
  );

  // cycles chip select has already been high, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cs_hi_cnt <= '1;
    else if (!cs_no)            cs_hi_cnt <= '0;
    else if (cs_hi_cnt != '1)   cs_hi_cnt <= cs_hi_cnt + TW'(1);
  end

  AST_READY_AFTER_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> (cs_hi_cnt >= TW'(MIN_REC - 1))); // R9
  AST_DC_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && $past(!cs_no)) |-> $stable(dc_o)); // R3
  AST_ERR_NO_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_err_o && ph_q == PH_IDLE) |=> cs_no); // R1
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !in_ready_o); // R2
endmodule

// File: tb/disp_wr_engine_tb.sv
module disp_wr_engine_tb;
  localparam int PAR_SETUP = 2, PAR_ACT = 8, PAR_DSU = 5, PAR_HOLD = 1, PAR_CYC = 38;
  localparam int SCK_LO = 7, SCK_HI = 6, SPI_CSS = 3, SPI_CSH = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic in_valid_i = 1'b0, in_is_data_i = 1'b0;
  logic [7:0] in_data_i = '0;
  logic in_ready_o, mode_err_o, cs_no, dc_o, en_rd_o, rw_wr_o;
  logic [7:0] bus_o;

  always #4 clk_i = ~clk_i;

  disp_wr_engine #(
    .PAR_SETUP(PAR_SETUP), .PAR_ACT(PAR_ACT), .PAR_DSU(PAR_DSU), .PAR_HOLD(PAR_HOLD),
    .PAR_CYC(PAR_CYC), .SCK_LO(SCK_LO), .SCK_HI(SCK_HI), .SPI_CSS(SPI_CSS), .SPI_CSH(SPI_CSH)
  ) u_dut (.*);

  typedef struct packed { logic [1:0] mode; logic dc; logic [7:0] b; } item_t;
  item_t exp_q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // driver
  task automatic send(input logic [1:0] m, input logic [7:0] b, input logic dc, input bit flip);
    @(negedge clk_i);
    mode_i = m;
    #1;
    while (!in_ready_o) begin @(negedge clk_i); #1; end
    in_valid_i = 1'b1; in_data_i = b; in_is_data_i = dc;
    exp_q.push_back(item_t'{m, dc, b});
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk(!in_ready_o, "R2 ready low while busy", in_ready_o, 0);
    if (flip) begin
      repeat (10) @(negedge clk_i);
      mode_i = 2'b11;  // R11 mode change mid-transfer
    end
  endtask

  // monitor
  item_t cur;
  bit in_frame = 0, had = 0, rdy_chk = 0;
  logic pcs = 1, pe = 0, pw = 0, psck = 0, dc0 = 0;
  int cnt, run, first_act, latch_cnt, latches, since_latch, nbits, lo_run, hi_run, since_fall;
  int cs_hi = 0, last_rec = 0, min_lo_first, min_lo, min_hi;
  logic [7:0] sh, latched;
  bit bad_dc, bad_bus, bad_strb, bad_act, bad_sdat;
  logic hold_bit;

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (pcs && !cs_no) begin
        if (exp_q.size() == 0) chk(0, "R9 unexpected frame", 1, 0);
        else cur = exp_q.pop_front();
        in_frame = 1; rdy_chk = 0; cnt = 1; run = 0; first_act = 0; latch_cnt = 0;
        latches = 0; since_latch = 0; nbits = 0; lo_run = 1; hi_run = 0; since_fall = 0;
        sh = 0; latched = 0; dc0 = dc_o; min_lo_first = -1; min_lo = 1000; min_hi = 1000;
        bad_dc = 0; bad_bus = 0; bad_strb = 0; bad_act = 0; bad_sdat = 0;
        if (cur.mode[1]) begin
          if (bus_o != cur.b) bad_bus = 1;
        end
      end else if (in_frame && !cs_no) begin
        cnt++;
        if (dc_o != dc0) bad_dc = 1;
        if (cur.mode[1]) begin : par
          logic act;
          if (bus_o != cur.b) bad_bus = 1;
          if (cur.mode[0]) begin act = en_rd_o; if (rw_wr_o) bad_strb = 1; end
          else begin act = !rw_wr_o; if (!en_rd_o) bad_strb = 1; end
          if (latches > 0) since_latch++;
          if (act) begin
            if (run == 0 && latches == 0) first_act = cnt;
            run++;
          end else if (run > 0) begin
            if (run < PAR_ACT) bad_act = 1;
            latches++; latched = bus_o; latch_cnt = cnt; since_latch = 1; run = 0;
          end
        end else begin : ser
          logic sck;
          sck = bus_o[0];
          if (bus_o[7:2] != 0 || en_rd_o || rw_wr_o) bad_strb = 1;
          if (sck && !psck) begin
            sh = {sh[6:0], bus_o[1]}; hold_bit = bus_o[1]; nbits++;
            if (nbits == 1) min_lo_first = lo_run;
            else if (lo_run < min_lo) min_lo = lo_run;
            hi_run = 1;
          end else if (sck) begin
            hi_run++;
            if (bus_o[1] != hold_bit) bad_sdat = 1;
          end else if (psck) begin
            if (hi_run < min_hi) min_hi = hi_run;
            lo_run = 1; since_fall = 1;
          end else begin
            lo_run++; since_fall++;
          end
          psck = sck;
        end
      end else if (in_frame && cs_no) begin
        in_frame = 0; had = 1; cs_hi = 1; psck = 0;
        chk(dc0 == cur.dc && !bad_dc, "R3 dc level/stability", dc0, cur.dc);
        if (cur.mode[1]) begin
          last_rec = PAR_CYC;
          chk(latches == 1, "R9 one latch per frame", latches, 1);
          if (cur.mode[0]) chk(latched == cur.b && !bad_strb, "R4 enable-bus byte", latched, cur.b);
          else             chk(latched == cur.b && !bad_strb, "R5 strobe-pair byte", latched, cur.b);
          chk(!bad_act && !bad_bus, "R6 strobe width and bus stable", bad_act, 0);
          chk(first_act - 1 >= PAR_SETUP, "R6 setup before strobe", first_act - 1, PAR_SETUP);
          chk(latch_cnt - 1 >= PAR_DSU, "R6 data setup to latch", latch_cnt - 1, PAR_DSU);
          chk(since_latch >= PAR_HOLD, "R6 hold after latch", since_latch, PAR_HOLD);
        end else begin
          last_rec = SCK_LO + SCK_HI;
          chk(nbits == 8 && sh == cur.b, "R7 serial byte msb first", sh, cur.b);
          chk(!bad_strb, "R7 unused lines low", bad_strb, 0);
          chk(min_lo_first >= SPI_CSS + SCK_LO, "R8 cs setup to first clock", min_lo_first, SPI_CSS + SCK_LO);
          chk(min_lo >= SCK_LO && min_hi >= SCK_HI && !bad_sdat, "R8 clock phases", min_lo, SCK_LO);
          chk(since_fall >= SPI_CSH, "R8 cs hold after last clock", since_fall, SPI_CSH);
        end
      end else if (cs_no) begin
        cs_hi++;
      end
      if (had && cs_no && in_ready_o && !rdy_chk && !in_frame) begin
        rdy_chk = 1;
        chk(cs_hi >= last_rec, "R9 gap before ready", cs_hi, last_rec);
      end
      pcs = cs_no;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    chk(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    bit stayed;
    repeat (3) @(negedge clk_i);
    chk(cs_no && !en_rd_o && !rw_wr_o && !dc_o && bus_o == 0, "R10 reset levels",
        {cs_no, en_rd_o, rw_wr_o, dc_o, bus_o}, 12'h800);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(in_ready_o && !mode_err_o, "R10 ready after reset", {in_ready_o, mode_err_o}, 2);

    // R1: unsupported code
    mode_i = 2'b01; in_valid_i = 1'b1; in_data_i = 8'hA5;
    repeat (2) @(negedge clk_i);
    chk(mode_err_o && !in_ready_o, "R1 error flag and no ready", {mode_err_o, in_ready_o}, 2);
    stayed = 1;
    repeat (30) begin @(negedge clk_i); if (!cs_no) stayed = 0; end
    chk(stayed, "R1 no frame in 3-wire code", stayed, 1);
    in_valid_i = 1'b0; mode_i = 2'b00;
    repeat (2) @(negedge clk_i);
    chk(!mode_err_o, "R1 error clears", mode_err_o, 0);

    // idle strobe levels
    mode_i = 2'b10; repeat (2) @(negedge clk_i);
    chk(en_rd_o && rw_wr_o, "R5 idle strobes high", {en_rd_o, rw_wr_o}, 3);
    mode_i = 2'b11; repeat (2) @(negedge clk_i);
    chk(!en_rd_o && !rw_wr_o, "R4 idle strobes low", {en_rd_o, rw_wr_o}, 0);

    send(2'b11, 8'hAF, 1'b0, 0);
    send(2'b11, 8'h5A, 1'b1, 0);
    send(2'b11, 8'hFF, 1'b1, 0);
    send(2'b10, 8'h00, 1'b1, 0);
    send(2'b10, 8'hC3, 1'b0, 0);
    send(2'b00, 8'h81, 1'b0, 0);
    send(2'b00, 8'h3C, 1'b1, 0);
    send(2'b00, 8'h01, 1'b1, 1);   // R11 mode flips mid-frame
    send(2'b10, 8'h7E, 1'b1, 0);
    send(2'b00, 8'hFE, 1'b0, 0);
    send(2'b11, 8'h96, 1'b1, 0);

    while (exp_q.size() != 0 || !cs_no) @(negedge clk_i);
    repeat (60) @(negedge clk_i);
    chk(exp_q.size() == 0 && cs_no, "R9 all bytes framed", exp_q.size(), 0);
    summary();
  end
endmodule